// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel flash model. It watches synchronous write strobes that each carry an address and a data byte, and matches them against keyed multi-write sequences. Every command opens with a two-write unlock key on two fixed addresses. Erase and boot-region locking also need a second key before the final byte. A recognised sequence can launch a byte program or a whole-array erase on a separate storage and timing engine, set a sticky boot-region lock, or move the read path into and out of an identification mode.

The engine receives a one-cycle start pulse together with the operation kind, the target address and the data byte. It reports back through a busy input. The read side is a combinational multiplexer. Outside identification mode it passes array data through unchanged. Inside that mode it returns fixed vendor and device codes and the lock flag. The array itself, analog timing and pin filtering belong elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock key is data AA written to key address 5555h, then data 55 written to key address 2AAAh. Only the low KEY_W (default 15) address bits are compared, so an address whose upper bits are set but whose low bits match is accepted.
- R2: The key, then A0 to 5555h, then one further write makes the next cycle carry op_start=1, op_kind=1 (program), and op_addr/op_data equal to the address and data of that fourth write.
- R3: The key, then 80 to 5555h, the key again, then 10 to 5555h makes the next cycle carry op_start=1 with op_kind=2 (erase).
- R4: The same six-write pattern ending in 40 instead of 10 sets boot_locked in the next cycle and produces no op_start. boot_locked survives rst_n, and only lock_clr clears it.
- R5: The key followed by 90 to 5555h sets id_mode in the next cycle.
- R6: id_mode clears after either the key followed by F0 to 5555h, or a single F0 written to any address while no sequence is in progress.
- R7: While id_mode is set, rd_data shows 1Fh at address 0, 0Bh at address 1, and {7'b0, boot_locked} at address 2. All other addresses read 00h.
- R8: While id_mode is clear, rd_data equals arr_rdata for every address.
- R9: A write that does not match the step it is expected to complete returns the sequencer to idle with no start pulse, no mode change and no lock change.
- R10: A write presented while eng_busy is high is ignored entirely, and the sequencer keeps its current step.
- R11: A program target inside the boot region (address below 2^BOOT_W, default 2000h) while boot_locked is set produces no op_start. Targets outside the region still start.
- R12: op_start is high for exactly one cycle per accepted program or erase. op_kind, op_addr and op_data hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for sequencer, mode and outputs (not the lock) |
| lock_clr | input | 1 | Asynchronous factory clear of the boot lock flag |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| eng_busy | input | 1 | Engine busy; writes are ignored while high |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Array read data from the storage engine |
| rd_data | output | 8 | Read data to the bus |
| op_start | output | 1 | One-cycle start pulse to the engine |
| op_kind | output | 2 | 1 = program, 2 = erase |
| op_addr | output | ADDR_W | Program target address |
| op_data | output | 8 | Program data byte |
| id_mode | output | 1 | Identification read mode active |
| boot_locked | output | 1 | Boot-region lock flag |

## Verification
The bench uses the defaults ADDR_W=18, KEY_W=15 and BOOT_W=13. With these values three address bits lie above the compared field, so the aliasing of key addresses can be driven directly. The boot region spans 8K bytes, so program targets can be placed on either side of its edge. Identification codes and the lock bit are read through rd_data. The lock is driven across an rst_n pulse and a lock_clr pulse to show which of the two clears it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PGM,
    S_EXT1,
    S_EXT2,
    S_EXT3
  } seq_state_e;

  localparam logic [7:0] D_KEY1  = 8'hAA;
  localparam logic [7:0] D_KEY2  = 8'h55;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_EXT   = 8'h80;
  localparam logic [7:0] D_ERASE = 8'h10;
  localparam logic [7:0] D_LOCK  = 8'h40;
  localparam logic [7:0] D_IDON  = 8'h90;
  localparam logic [7:0] D_IDOFF = 8'hF0;

  // Compare only the low w bits of an address against a key address.
  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] key,
                                    input int unsigned w);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return ((a ^ key) & m) == 32'd0;
  endfunction

  // True when every address bit at position w and above is zero.
  function automatic logic in_low_region(input logic [31:0] a, input int unsigned w);
    return (w >= 32) ? 1'b1 : ((a >> w) == 32'd0);
  endfunction

  // Byte returned by an identification-mode read.
  function automatic logic [7:0] id_byte(input logic [31:0] a, input logic lk,
                                         input logic [7:0] mfr, input logic [7:0] dev);
    case (a)
      32'd0:   return mfr;
      32'd1:   return dev;
      32'd2:   return {7'b0, lk};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int unsigned   ADDR_W    = 18,
  parameter int unsigned   KEY_W     = 15,
  parameter int unsigned   BOOT_W    = 13,
  parameter logic [31:0]   KEY_ADDR1 = 32'h5555,
  parameter logic [31:0]   KEY_ADDR2 = 32'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_busy,
  input  logic              lock_q,
  output logic              ev_prog,
  output logic              ev_erase,
  output logic              ev_lock,
  output logic              ev_id_enter,
  output logic              ev_id_exit,
  output logic              ev_accept,
  output seq_state_e        state_q
);

  seq_state_e state_d;
  logic       hit1;
  logic       hit2;
  logic       tgt_boot;

  assign ev_accept = wr_en & ~eng_busy;
  assign hit1      = addr_hit(32'(wr_addr), KEY_ADDR1, KEY_W);
  assign hit2      = addr_hit(32'(wr_addr), KEY_ADDR2, KEY_W);
  assign tgt_boot  = in_low_region(32'(wr_addr), BOOT_W);

  always_comb begin
    state_d     = state_q;
    ev_prog     = 1'b0;
    ev_erase    = 1'b0;
    ev_lock     = 1'b0;
    ev_id_enter = 1'b0;
    ev_id_exit  = 1'b0;
    if (ev_accept) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (hit1 && wr_data == D_KEY1) state_d = S_KEY1;
          else if (wr_data == D_IDOFF)   ev_id_exit = 1'b1;
        end
        S_KEY1: begin
          if (hit2 && wr_data == D_KEY2) state_d = S_KEY2;
        end
        S_KEY2: begin
          if (hit1) begin
            case (wr_data)
              D_PROG:  state_d = S_PGM;
              D_EXT:   state_d = S_EXT1;
              D_IDON:  ev_id_enter = 1'b1;
              D_IDOFF: ev_id_exit  = 1'b1;
              default: state_d = S_IDLE;
            endcase
          end
        end
        S_PGM: begin
          if (!(lock_q && tgt_boot)) ev_prog = 1'b1;
        end
        S_EXT1: begin
          if (hit1 && wr_data == D_KEY1) state_d = S_EXT2;
        end
        S_EXT2: begin
          if (hit2 && wr_data == D_KEY2) state_d = S_EXT3;
        end
        S_EXT3: begin
          if (hit1 && wr_data == D_ERASE)     ev_erase = 1'b1;
          else if (hit1 && wr_data == D_LOCK) ev_lock  = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_clr,
  input  logic ev_lock,
  input  logic ev_id_enter,
  input  logic ev_id_exit,
  output logic id_mode_q,
  output logic lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           id_mode_q <= 1'b0;
    else if (ev_id_enter) id_mode_q <= 1'b1;
    else if (ev_id_exit)  id_mode_q <= 1'b0;
  end

  // Non-volatile lock: untouched by rst_n, cleared only by the factory input.
  always_ff @(posedge clk or posedge lock_clr) begin
    if (lock_clr)     lock_q <= 1'b0;
    else if (ev_lock) lock_q <= 1'b1;
  end

endmodule

// File: rtl/fcd_oplaunch.sv
module fcd_oplaunch
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_prog,
  input  logic              ev_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              op_start,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= ev_prog | ev_erase;
      if (ev_prog) begin
        op_kind <= OP_PROG;
        op_addr <= wr_addr;
        op_data <= wr_data;
      end else if (ev_erase) begin
        op_kind <= OP_ERASE;
        op_addr <= '0;
        op_data <= 8'hFF;
      end
    end
  end

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h0B
) (
  input  logic              id_mode,
  input  logic              lock_q,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data
);

  always_comb begin
    if (id_mode) rd_data = id_byte(32'(rd_addr), lock_q, MFR_CODE, DEV_CODE);
    else         rd_data = arr_rdata;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned KEY_W     = 15,
  parameter int unsigned BOOT_W    = 13,
  parameter logic [31:0] KEY_ADDR1 = 32'h5555,
  parameter logic [31:0] KEY_ADDR2 = 32'h2AAA,
  parameter logic [7:0]  MFR_CODE  = 8'h1F,
  parameter logic [7:0]  DEV_CODE  = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_mode,
  output logic              boot_locked
);

  // Named internal events, visible to the bound checker.
  logic       ev_prog;
  logic       ev_erase;
  logic       ev_lock;
  logic       ev_id_enter;
  logic       ev_id_exit;
  logic       ev_accept;
  seq_state_e seq_state;
  op_kind_e   kind_q;

  fcd_seq #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .BOOT_W(BOOT_W),
    .KEY_ADDR1(KEY_ADDR1), .KEY_ADDR2(KEY_ADDR2)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .lock_q(boot_locked),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_lock(ev_lock),
    .ev_id_enter(ev_id_enter), .ev_id_exit(ev_id_exit), .ev_accept(ev_accept),
    .state_q(seq_state)
  );

  fcd_mode u_mode (
    .clk(clk), .rst_n(rst_n), .lock_clr(lock_clr), .ev_lock(ev_lock),
    .ev_id_enter(ev_id_enter), .ev_id_exit(ev_id_exit),
    .id_mode_q(id_mode), .lock_q(boot_locked)
  );

  fcd_oplaunch #(.ADDR_W(ADDR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .op_start(op_start), .op_kind(kind_q), .op_addr(op_addr), .op_data(op_data)
  );

  assign op_kind = kind_q;

  fcd_rdmux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .id_mode(id_mode), .lock_q(boot_locked), .rd_addr(rd_addr),
    .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BOOT_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_clr,
  input logic              eng_busy,
  input logic              wr_en,
  input logic              op_start,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic              id_mode,
  input logic              boot_locked,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              ev_prog,
  input logic              ev_erase,
  input logic              ev_lock,
  input logic              ev_id_enter,
  input logic              ev_id_exit
);

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_prog, ev_erase, ev_lock, ev_id_enter, ev_id_exit})); // R9

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R12

  AST_START_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (op_kind == 2'd1 || op_kind == 2'd2)); // R12

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_en) |=> (!op_start && $stable(id_mode))); // R10

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || lock_clr)
    (boot_locked === 1'b1) |=> boot_locked); // R4

  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 2'd1 && boot_locked === 1'b1)
      |-> ((op_addr >> BOOT_W) != '0)); // R11

  AST_ID_VENDOR: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == '0) |-> (rd_data == 8'h1F)); // R7

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_clr(lock_clr), .eng_busy(eng_busy), .wr_en(wr_en),
  .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .id_mode(id_mode),
  .boot_locked(boot_locked), .rd_addr(rd_addr), .rd_data(rd_data),
  .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_lock(ev_lock),
  .ev_id_enter(ev_id_enter), .ev_id_exit(ev_id_exit)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock_clr = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          eng_busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    arr_rdata = 8'h00;
  logic [7:0]    rd_data;
  logic          op_start;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          id_mode;
  logic          boot_locked;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .lock_clr(lock_clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .id_mode(id_mode), .boot_locked(boot_locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write; returns at the falling edge right after the sampling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic key(input logic [AW-1:0] hi);
    wr(hi | 18'h05555, 8'hAA);
    wr(hi | 18'h02AAA, 8'h55);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_addr = a;
    #1;
  endtask

  task automatic t_reset();
    chk("R12 reset op_start", 32'(op_start), 0);
    chk("R5 reset id_mode", 32'(id_mode), 0);
    chk("R4 factory lock clear", 32'(boot_locked), 0);
  endtask

  task automatic t_passthru();
    arr_rdata = 8'h5A; rd(18'h00000);
    chk("R8 pass addr0", 32'(rd_data), 32'h5A);
    arr_rdata = 8'hC3; rd(18'h00002);
    chk("R8 pass addr2", 32'(rd_data), 32'hC3);
  endtask

  task automatic t_program();
    key(18'h00000);
    wr(18'h05555, 8'hA0);
    wr(18'h12345, 8'h3C);
    chk("R2 start", 32'(op_start), 1);
    chk("R2 kind", 32'(op_kind), 1);
    chk("R2 addr", 32'(op_addr), 32'h12345);
    chk("R2 data", 32'(op_data), 32'h3C);
    @(negedge clk);
    chk("R12 pulse width", 32'(op_start), 0);
    chk("R12 addr held", 32'(op_addr), 32'h12345);
    // R1: aliased key addresses with upper bits set
    key(18'h38000);
    wr(18'h3D555, 8'hA0);
    wr(18'h20001, 8'h81);
    chk("R1 aliased key start", 32'(op_start), 1);
    chk("R1 aliased key addr", 32'(op_addr), 32'h20001);
  endtask

  task automatic t_erase();
    key(18'h00000);
    wr(18'h05555, 8'h80);
    key(18'h00000);
    wr(18'h05555, 8'h10);
    chk("R3 start", 32'(op_start), 1);
    chk("R3 kind", 32'(op_kind), 2);
    chk("R3 no lock", 32'(boot_locked), 0);
  endtask

  task automatic t_id_mode();
    key(18'h00000);
    wr(18'h05555, 8'h90);
    chk("R5 enter", 32'(id_mode), 1);
    arr_rdata = 8'h77;
    rd(18'h00000); chk("R7 vendor", 32'(rd_data), 32'h1F);
    rd(18'h00001); chk("R7 device", 32'(rd_data), 32'h0B);
    rd(18'h00002); chk("R7 lock bit", 32'(rd_data), 32'h00);
    rd(18'h10000); chk("R7 other addr", 32'(rd_data), 32'h00);
    wr(18'h00777, 8'hF0);
    chk("R6 single F0 exit", 32'(id_mode), 0);
    rd(18'h00000); chk("R8 after exit", 32'(rd_data), 32'h77);
    key(18'h00000);
    wr(18'h05555, 8'h90);
    key(18'h00000);
    wr(18'h05555, 8'hF0);
    chk("R6 keyed exit", 32'(id_mode), 0);
  endtask

  task automatic t_mismatch();
    key(18'h00000);
    wr(18'h05555, 8'h77);
    wr(18'h04000, 8'h11);
    chk("R9 bad command byte", 32'(op_start), 0);
    key(18'h00000);
    wr(18'h05555, 8'h80);
    key(18'h00000);
    wr(18'h01234, 8'h10);
    chk("R9 bad final addr", 32'(op_start), 0);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAB, 8'h55);
    wr(18'h05555, 8'h90);
    chk("R9 bad key addr", 32'(id_mode), 0);
    chk("R9 no lock", 32'(boot_locked), 0);
  endtask

  task automatic t_busy();
    key(18'h00000);
    eng_busy = 1'b1;
    wr(18'h00100, 8'h77);
    chk("R10 busy write no start", 32'(op_start), 0);
    eng_busy = 1'b0;
    wr(18'h05555, 8'hA0);
    wr(18'h04000, 8'h3C);
    chk("R10 step kept", 32'(op_start), 1);
    key(18'h00000);
    wr(18'h05555, 8'hA0);
    eng_busy = 1'b1;
    wr(18'h04004, 8'h99);
    chk("R10 busy target ignored", 32'(op_start), 0);
    eng_busy = 1'b0;
    wr(18'h00000, 8'hAA);
    wr(18'h00000, 8'hAA);
  endtask

  task automatic t_lock();
    key(18'h00000);
    wr(18'h05555, 8'h80);
    key(18'h00000);
    wr(18'h05555, 8'h40);
    chk("R4 lock set", 32'(boot_locked), 1);
    chk("R4 no start", 32'(op_start), 0);
    key(18'h00000);
    wr(18'h05555, 8'hA0);
    wr(18'h01FFF, 8'h00);
    chk("R11 boot target blocked", 32'(op_start), 0);
    key(18'h00000);
    wr(18'h05555, 8'hA0);
    wr(18'h02000, 8'h42);
    chk("R11 outside boot ok", 32'(op_start), 1);
    key(18'h00000);
    wr(18'h05555, 8'h90);
    rd(18'h00002); chk("R7 lock bit set", 32'(rd_data), 32'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R4 lock survives reset", 32'(boot_locked), 1);
    chk("R5 reset exits id", 32'(id_mode), 0);
    @(negedge clk); lock_clr = 1'b1;
    @(negedge clk); lock_clr = 1'b0;
    chk("R4 factory clear", 32'(boot_locked), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    lock_clr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_program();
    t_erase();
    t_id_mode();
    t_mismatch();
    t_busy();
    t_lock();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule